// File: doc/BRIEF.md
# I/O Slave Decode and Request Router

This block sits between a 12-bit ISA-style I/O host bus and the rest of a peripheral. It compares each bus access against a programmed 16-byte window and turns a matching access into one-cycle internal read and write strobes, with the low address nibble as a register index. For as long as the access matches, it also holds an active-low enable for an external bus transceiver. The same block steers one internal interrupt line and one internal DMA request onto one of several selectable request pins. Each pin is modelled as a value plus an output enable, so a pin that is not selected floats.

After reset the block answers no address and drives no request pin until software writes its configuration through the configuration port. A chip-enable input overrides everything: while it is low, every request pin floats and no access is decoded. When a routing select changes, the old pin is released one full cycle before the new pin is driven. This means two devices sharing the request lines never see both pins driven at once.

The bus inputs are assumed to be synchronous to `clk`.

Top module: `isa_slave_front`

## Requirements
- R1: After reset the block decodes nothing: `xcvr_en_n` is 1, `rd_stb` and `wr_stb` are 0, and `irq_oe` and `drq_oe` are all 0 until a configuration write sets `cfg_dec_en`.
- R2: An access matches, and `xcvr_en_n` is 0 in the same cycle, exactly when all of these hold: `aen_n` is 0, `chip_en` is 1, decoding is enabled, `bus_addr[11:10]` is 0, `bus_addr[9:4]` equals the programmed base, and `ior_n` or `iow_n` is 0.
- R3: The first cycle of a matching read (or write) produces a single-cycle `rd_stb` (or `wr_stb`) on the next cycle, with `reg_idx` set to `bus_addr[3:0]`. Holding the strobe low for longer produces no further pulse.
- R4: While `chip_en` is 0, all of `irq_oe` and `drq_oe` are 0 and no access matches.
- R5: When interrupt routing is on, exactly the pin numbered `cfg_irq_sel` has its output enable set, and its value follows `int_req`.
- R6: When DMA routing is on with `cfg_drq_sel` below 3, the selected pin is driven. Its value is 0 when no request is pending and 1 while one is pending.
- R7: A `dma_req` pulse sets the pending request. The request is cleared when the acknowledge bit of the selected channel (`dack_n[sel]`) is 0 together with `ior_n` or `iow_n` low. An acknowledge on an unselected channel has no effect. A new request arriving in the same cycle as an acknowledge keeps the request pending.
- R8: When a configuration write moves an active route to a different pin, all pins of that route are released for one cycle, and the new pin is enabled on the cycle after.
- R9: A configuration write with `cfg_dec_en` at 0 stops all decoding and releases all pins. A DMA select value of 3 turns DMA routing off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Host I/O address |
| aen_n | input | 1 | Active-low address enable |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| chip_en | input | 1 | Active-high chip enable override |
| cfg_we | input | 1 | Configuration write pulse |
| cfg_dec_en | input | 1 | Decode enable field |
| cfg_base | input | 6 | Base address bits [9:4] |
| cfg_irq_on | input | 1 | Interrupt routing on |
| cfg_irq_sel | input | 2 | Interrupt pin select |
| cfg_drq_on | input | 1 | DMA routing on |
| cfg_drq_sel | input | 2 | DMA pin select (3 = off) |
| int_req | input | 1 | Internal interrupt level |
| dma_req | input | 1 | Internal DMA request pulse |
| dack_n | input | 3 | Active-low DMA acknowledges |
| rd_stb | output | 1 | Internal read strobe |
| wr_stb | output | 1 | Internal write strobe |
| reg_idx | output | 4 | Register index of last strobe |
| xcvr_en_n | output | 1 | Active-low transceiver enable |
| irq_val | output | 4 | Interrupt pin values |
| irq_oe | output | 4 | Interrupt pin output enables |
| drq_val | output | 3 | DMA request pin values |
| drq_oe | output | 3 | DMA request pin output enables |

## Verification
The assertions check the following on every cycle:
- the transceiver enable is never low without a qualifying bus access;
- each strobe lasts one cycle and comes from the right bus strobe;
- the pins float under chip-enable low;
- at most one pin per route is enabled;
- a driven pin never jumps straight from one pin to another;
- a driven DMA pin reflects the pending request.

Only the bench scenarios show the rest:
- the exact match conditions against the programmed base;
- the register index value;
- the one-cycle gap and its timing;
- the response to acknowledges on the right and wrong channels;
- set-over-clear priority;
- the disabled state after reset and after a disabling write.

// File: rtl/isa_front_pkg.sv
package isa_front_pkg;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 4;
  localparam int TOP_W  = 2;
  localparam int BASE_W = ADDR_W - TOP_W - OFS_W;

  // window match: top bits clear and block bits equal to base
  function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                      input logic [BASE_W-1:0] base);
    return (a[ADDR_W-1 -: TOP_W] == '0) && (a[OFS_W +: BASE_W] == base);
  endfunction

  // bus qualification: address enable low, chip selected, some strobe low
  function automatic logic bus_live(input logic aen_n, input logic ce,
                                    input logic ior_n, input logic iow_n);
    return !aen_n && ce && (!ior_n || !iow_n);
  endfunction
endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
  import isa_front_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              aen_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              chip_en,
  input  logic              dec_en,
  input  logic [BASE_W-1:0] base,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [OFS_W-1:0]  reg_idx,
  output logic              xcvr_en_n
);
  logic match;
  logic rd_hit_q, wr_hit_q;
  logic rd_first, wr_first;

  assign match    = dec_en && bus_live(aen_n, chip_en, ior_n, iow_n)
                    && window_hit(bus_addr, base);
  assign rd_hit   = match && !ior_n;
  assign wr_hit   = match && !iow_n;
  assign rd_first = rd_hit && !rd_hit_q;
  assign wr_first = wr_hit && !wr_hit_q;
  assign xcvr_en_n = !match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit_q <= 1'b0;
      wr_hit_q <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      reg_idx  <= '0;
    end else begin
      rd_hit_q <= rd_hit;
      wr_hit_q <= wr_hit;
      rd_stb   <= rd_first;
      wr_stb   <= wr_first;
      if (rd_first || wr_first) reg_idx <= bus_addr[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/isa_req_router.sv
module isa_req_router #(
  parameter int N     = 4,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             new_on,
  input  logic [SEL_W-1:0] new_sel,
  input  logic             gate,
  output logic [N-1:0]     sel_mask,
  output logic [N-1:0]     oe
);
  logic             act_on, gap, nxt_on;
  logic [SEL_W-1:0] act_sel, nxt_sel;
  logic             req_on;

  // a select outside the pin range counts as routing off
  assign req_on = new_on && (32'(new_sel) < N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_on  <= 1'b0;
      act_sel <= '0;
      gap     <= 1'b0;
      nxt_on  <= 1'b0;
      nxt_sel <= '0;
    end else if (upd) begin
      if (act_on && (!req_on || new_sel != act_sel)) begin
        act_on  <= 1'b0;
        gap     <= 1'b1;
        nxt_on  <= req_on;
        nxt_sel <= new_sel;
      end else if (!act_on) begin
        act_on  <= req_on;
        act_sel <= new_sel;
        gap     <= 1'b0;
      end
    end else if (gap) begin
      act_on  <= nxt_on;
      act_sel <= nxt_sel;
      gap     <= 1'b0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign sel_mask[i] = act_on && (act_sel == SEL_W'(i));
    assign oe[i]       = gate && sel_mask[i];
  end
endmodule

// File: rtl/isa_dma_track.sv
module isa_dma_track #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_set,
  input  logic [N-1:0] dack_n,
  input  logic [N-1:0] sel_mask,
  input  logic         ior_n,
  input  logic         iow_n,
  output logic         ack_evt,
  output logic         pending
);
  assign ack_evt = (|(~dack_n & sel_mask)) && (!ior_n || !iow_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (req_set) pending <= 1'b1;
    else if (ack_evt) pending <= 1'b0;
  end
endmodule

// File: rtl/isa_slave_front.sv
module isa_slave_front
  import isa_front_pkg::*;
#(
  parameter int IRQ_N = 4,
  parameter int DRQ_N = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [11:0]                bus_addr,
  input  logic                       aen_n,
  input  logic                       ior_n,
  input  logic                       iow_n,
  input  logic                       chip_en,
  input  logic                       cfg_we,
  input  logic                       cfg_dec_en,
  input  logic [5:0]                 cfg_base,
  input  logic                       cfg_irq_on,
  input  logic [$clog2(IRQ_N)-1:0]   cfg_irq_sel,
  input  logic                       cfg_drq_on,
  input  logic [$clog2(DRQ_N+1)-1:0] cfg_drq_sel,
  input  logic                       int_req,
  input  logic                       dma_req,
  input  logic [DRQ_N-1:0]           dack_n,
  output logic                       rd_stb,
  output logic                       wr_stb,
  output logic [3:0]                 reg_idx,
  output logic                       xcvr_en_n,
  output logic [IRQ_N-1:0]           irq_val,
  output logic [IRQ_N-1:0]           irq_oe,
  output logic [DRQ_N-1:0]           drq_val,
  output logic [DRQ_N-1:0]           drq_oe
);
  localparam int IRQ_SW = $clog2(IRQ_N);
  localparam int DRQ_SW = $clog2(DRQ_N + 1);

  logic              dec_en;
  logic [BASE_W-1:0] base_q;
  logic              rd_hit, wr_hit;
  logic              route_gate;
  logic [IRQ_N-1:0]  irq_mask;
  logic [DRQ_N-1:0]  drq_mask;
  logic              dma_ack_evt;
  logic              dma_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_en <= 1'b0;
      base_q <= '0;
    end else if (cfg_we) begin
      dec_en <= cfg_dec_en;
      base_q <= cfg_base;
    end
  end

  assign route_gate = chip_en && dec_en;

  isa_addr_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .aen_n     (aen_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .chip_en   (chip_en),
    .dec_en    (dec_en),
    .base      (base_q),
    .rd_hit    (rd_hit),
    .wr_hit    (wr_hit),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .reg_idx   (reg_idx),
    .xcvr_en_n (xcvr_en_n)
  );

  isa_req_router #(.N(IRQ_N), .SEL_W(IRQ_SW)) u_irq_rt (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (cfg_we),
    .new_on   (cfg_irq_on && cfg_dec_en),
    .new_sel  (cfg_irq_sel),
    .gate     (route_gate),
    .sel_mask (irq_mask),
    .oe       (irq_oe)
  );

  isa_req_router #(.N(DRQ_N), .SEL_W(DRQ_SW)) u_drq_rt (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (cfg_we),
    .new_on   (cfg_drq_on && cfg_dec_en),
    .new_sel  (cfg_drq_sel),
    .gate     (route_gate),
    .sel_mask (drq_mask),
    .oe       (drq_oe)
  );

  isa_dma_track #(.N(DRQ_N)) u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_set  (dma_req),
    .dack_n   (dack_n),
    .sel_mask (drq_mask),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .ack_evt  (dma_ack_evt),
    .pending  (dma_pending)
  );

  assign irq_val = irq_oe & {IRQ_N{int_req}};
  assign drq_val = drq_oe & {DRQ_N{dma_pending}};
endmodule

// File: rtl/isa_slave_front_chk.sv
module isa_slave_front_chk #(
  parameter int IRQ_N = 4,
  parameter int DRQ_N = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic             aen_n,
  input logic             ior_n,
  input logic             iow_n,
  input logic             chip_en,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             xcvr_en_n,
  input logic [IRQ_N-1:0] irq_oe,
  input logic [DRQ_N-1:0] drq_oe,
  input logic [DRQ_N-1:0] drq_val,
  input logic             dma_pending
);
  a_r2_enable_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en_n |-> (chip_en && !aen_n && bus_addr[11:10] == 2'b00 && (!ior_n || !iow_n)));

  a_r3_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r3_rd_from_ior: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(!ior_n));

  a_r4_ce_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (irq_oe == '0 && drq_oe == '0 && xcvr_en_n));

  a_r5_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_oe));

  a_r6_drq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drq_oe));

  a_r7_drq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_oe != '0) |-> ((drq_val != '0) == dma_pending));

  a_r8_irq_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe != '0 && $past(irq_oe) != '0) |-> irq_oe == $past(irq_oe));

  a_r8_drq_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_oe != '0 && $past(drq_oe) != '0) |-> drq_oe == $past(drq_oe));
endmodule

bind isa_slave_front isa_slave_front_chk #(.IRQ_N(IRQ_N), .DRQ_N(DRQ_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .aen_n       (aen_n),
  .ior_n       (ior_n),
  .iow_n       (iow_n),
  .chip_en     (chip_en),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .xcvr_en_n   (xcvr_en_n),
  .irq_oe      (irq_oe),
  .drq_oe      (drq_oe),
  .drq_val     (drq_val),
  .dma_pending (dma_pending)
);

// File: tb/isa_slave_front_tb_top.sv
module isa_slave_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        aen_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1, chip_en = 1'b1;
  logic        cfg_we = 1'b0, cfg_dec_en = 1'b0, cfg_irq_on = 1'b0, cfg_drq_on = 1'b0;
  logic [5:0]  cfg_base = '0;
  logic [1:0]  cfg_irq_sel = '0, cfg_drq_sel = '0;
  logic        int_req = 1'b0, dma_req = 1'b0;
  logic [2:0]  dack_n = 3'b111;
  logic        rd_stb, wr_stb, xcvr_en_n;
  logic [3:0]  reg_idx, irq_val, irq_oe;
  logic [2:0]  drq_val, drq_oe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  isa_slave_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .aen_n(aen_n),
    .ior_n(ior_n), .iow_n(iow_n), .chip_en(chip_en), .cfg_we(cfg_we),
    .cfg_dec_en(cfg_dec_en), .cfg_base(cfg_base), .cfg_irq_on(cfg_irq_on),
    .cfg_irq_sel(cfg_irq_sel), .cfg_drq_on(cfg_drq_on), .cfg_drq_sel(cfg_drq_sel),
    .int_req(int_req), .dma_req(dma_req), .dack_n(dack_n),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_idx(reg_idx), .xcvr_en_n(xcvr_en_n),
    .irq_val(irq_val), .irq_oe(irq_oe), .drq_val(drq_val), .drq_oe(drq_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic en, input logic [5:0] base,
                           input logic ion, input logic [1:0] isel,
                           input logic don, input logic [1:0] dsel);
    cfg_we = 1'b1; cfg_dec_en = en; cfg_base = base;
    cfg_irq_on = ion; cfg_irq_sel = isel; cfg_drq_on = don; cfg_drq_sel = dsel;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic bus_idle();
    aen_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
  endtask

  // expected match computed from the stated decode conditions
  function automatic bit exp_match(input logic [11:0] a, input logic [5:0] b,
                                   input bit en, input bit ce, input bit aen,
                                   input bit rn, input bit wn);
    return en && ce && !aen && (rn == 1'b0 || wn == 1'b0)
           && a[11] == 1'b0 && a[10] == 1'b0 && a[9:4] == b;
  endfunction

  function automatic logic [3:0] exp_irq_oe(input bit ce, input int sel);
    return ce ? (4'b0001 << sel) : 4'b0000;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] base;
    bit prev_rd, prev_wr;
    void'($urandom(32'h5EED1234));

    // R1: reset state
    repeat (3) cyc();
    check("R1 xcvr in reset", xcvr_en_n, 1);
    check("R1 irq_oe in reset", irq_oe, 0);
    rst_n = 1'b1;
    cyc();
    aen_n = 1'b0; ior_n = 1'b0; bus_addr = 12'h000;
    #1 check("R1 no decode before config", xcvr_en_n, 1);
    cyc();
    check("R1 no rd_stb before config", rd_stb, 0);
    check("R1 drq_oe before config", drq_oe, 0);
    bus_idle();
    cyc();

    // configure: base 0x22, irq pin 2, drq pin 1
    cfg_write(1'b1, 6'h22, 1'b1, 2'd2, 1'b1, 2'd1);
    check("R5 irq pin 2 enabled", irq_oe, 4'b0100);
    check("R6 drq pin 1 enabled", drq_oe, 3'b010);
    check("R6 drq low when idle", drq_val, 3'b000);

    // R2/R3 read
    bus_addr = 12'h225; aen_n = 1'b0; ior_n = 1'b0;
    #1 check("R2 read match", xcvr_en_n, 0);
    cyc();
    check("R3 rd_stb pulse", rd_stb, 1);
    check("R3 reg_idx", reg_idx, 4'h5);
    cyc();
    check("R3 no second pulse", rd_stb, 0);
    bus_idle();
    cyc();

    // R2 mismatches
    bus_addr = 12'hA25; aen_n = 1'b0; ior_n = 1'b0;
    #1 check("R2 upper bits block", xcvr_en_n, 1);
    bus_addr = 12'h235;
    #1 check("R2 wrong base", xcvr_en_n, 1);
    bus_addr = 12'h22F; aen_n = 1'b1;
    #1 check("R2 aen high blocks", xcvr_en_n, 1);
    bus_idle();
    cyc();

    // R3 write
    bus_addr = 12'h22C; aen_n = 1'b0; iow_n = 1'b0;
    cyc();
    check("R3 wr_stb pulse", wr_stb, 1);
    check("R3 write reg_idx", reg_idx, 4'hC);
    bus_idle();
    cyc();

    // R5 interrupt value
    int_req = 1'b1;
    #1 check("R5 irq value", irq_val, 4'b0100);
    int_req = 1'b0;

    // R7 DMA request and acknowledges
    dma_req = 1'b1; cyc(); dma_req = 1'b0;
    check("R6 drq high when pending", drq_val, 3'b010);
    dack_n = 3'b110; ior_n = 1'b0; cyc();
    check("R7 wrong channel ack ignored", drq_val, 3'b010);
    dack_n = 3'b101; ior_n = 1'b1; cyc();
    check("R7 ack without strobe ignored", drq_val, 3'b010);
    iow_n = 1'b0; cyc();
    check("R7 matching ack clears", drq_val, 3'b000);
    bus_idle(); dack_n = 3'b111;
    dma_req = 1'b1; cyc();
    dack_n = 3'b101; iow_n = 1'b0; cyc();
    dma_req = 1'b0;
    check("R7 set wins over ack", drq_val, 3'b010);
    cyc();
    check("R7 later ack clears", drq_val, 3'b000);
    bus_idle(); dack_n = 3'b111;

    // R4 chip enable override
    chip_en = 1'b0; bus_addr = 12'h221; aen_n = 1'b0; ior_n = 1'b0;
    #1 check("R4 no match with ce low", xcvr_en_n, 1);
    check("R4 irq floats", irq_oe, 0);
    check("R4 drq floats", drq_oe, 0);
    cyc();
    check("R4 no strobe with ce low", rd_stb, 0);
    bus_idle(); chip_en = 1'b1;
    cyc();

    // R8 select change gap
    cfg_write(1'b1, 6'h22, 1'b1, 2'd0, 1'b1, 2'd1);
    check("R8 gap cycle releases irq", irq_oe, 0);
    check("R8 unchanged drq stays", drq_oe, 3'b010);
    cyc();
    check("R8 new irq pin", irq_oe, 4'b0001);

    // R9 drq select 3 = off
    cfg_write(1'b1, 6'h22, 1'b1, 2'd0, 1'b1, 2'd3);
    cyc();
    check("R9 drq sel 3 off", drq_oe, 0);

    // R9 disable
    cfg_write(1'b0, 6'h22, 1'b1, 2'd0, 1'b1, 2'd1);
    bus_addr = 12'h221; aen_n = 1'b0; ior_n = 1'b0;
    #1 check("R9 disabled no match", xcvr_en_n, 1);
    cyc();
    check("R9 disabled irq released", irq_oe, 0);
    bus_idle();
    cyc();

    // random phase: R2/R3/R4/R5
    base = 6'($urandom);
    cfg_write(1'b1, base, 1'b1, 2'd3, 1'b0, 2'd0);
    cyc();
    prev_rd = 0; prev_wr = 0;
    for (int k = 0; k < 3000; k++) begin
      bit hit, hr, hw, er, ew;
      logic [3:0] ofs;
      ofs = 4'($urandom);
      bus_addr = ($urandom % 3 != 0) ? {2'b00, base, ofs}
                                     : {2'($urandom), 6'($urandom), ofs};
      aen_n   = ($urandom % 5 == 0);
      chip_en = ($urandom % 7 != 0);
      ior_n   = ($urandom % 2 == 0);
      iow_n   = ($urandom % 3 != 0);
      #1;
      hit = exp_match(bus_addr, base, 1, chip_en, aen_n, ior_n, iow_n);
      hr = hit && !ior_n;
      hw = hit && !iow_n;
      check("R2 random match", xcvr_en_n, !hit);
      check("R4 random irq_oe", irq_oe, exp_irq_oe(chip_en, 3));
      er = hr && !prev_rd;
      ew = hw && !prev_wr;
      prev_rd = hr; prev_wr = hw;
      cyc();
      check("R3 random rd_stb", rd_stb, er);
      check("R3 random wr_stb", wr_stb, ew);
      if (er || ew) check("R3 random reg_idx", reg_idx, ofs);
    end
    bus_idle(); chip_en = 1'b1;
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule